// File: doc/BRIEF.md
# Supply Power-Fail Warning Logic

This block is the digital half of an early warning for a failing supply. It compares a sampled supply-voltage code against a threshold chosen by software. The code is in 10 mV units. When the supply drops under that threshold, the block sets a sticky warning event, which drives an interrupt only if software has enabled that interrupt. For as long as the low-supply condition lasts, the block also holds an inhibit line to the flash write controller. The analog comparator and the brownout reset are outside the block.

The warning is tied to entry into the low-supply state, not only to a falling crossing. The event therefore also fires in three other cases: when the block is switched on while the supply is already low, when the threshold is raised above the present supply, and when a sleeping comparator wakes up with the supply low. The comparator sleeps whenever the system is off or the high-frequency clock is stopped. While it sleeps it forgets its low-supply state, raises no event and asserts no inhibit. A 50 mV hysteresis stops the output from chattering around the threshold.

Top module: `pfw_warn`

## Requirements
- R1: After reset the enable bit, the threshold field, the event flag and the interrupt enable are 0, and `irq_o` and `wr_inhibit_o` are low.
- R2: A write with `cfg_we_i` loads the enable from `cfg_wdata_i[0]` and the 4-bit threshold code from `cfg_wdata_i[4:1]`. Codes 4 to 10 select a level of 170 + 10*(code-4) supply units, which is 1.7 V to 2.3 V. Codes below 4 act as code 4 and codes above 10 act as code 10.
- R3: While the comparator is active, a supply code strictly below the level sets `evt_o` at the clock edge that samples it. The comparator is active when it is enabled, `hfclk_on_i` is 1 and `sys_on_i` is 1.
- R4: Enabling the comparator while the supply is already below the level sets `evt_o` one edge after the configuration write.
- R5: Raising the threshold above the present supply sets `evt_o` one edge after the configuration write.
- R6: Once the supply is low, the low-supply state is left only when the supply code exceeds the level + 5. The event fires once for each entry into the low-supply state, not again while the state holds.
- R7: `wr_inhibit_o` is high exactly when the comparator is active and in the low-supply state.
- R8: While `sys_on_i` or `hfclk_on_i` is 0, or the comparator is disabled, the low-supply state is cleared, no event is raised and `wr_inhibit_o` is low. When the comparator becomes active again with the supply low, this counts as a fresh entry.
- R9: `evt_o` stays set until `evt_clr_i` clears it. If a new entry and a clear happen in the same cycle, the event stays set.
- R10: `inten_set_i` sets the interrupt enable and `inten_clr_i` clears it, with clear winning when both are high. `irq_o` is `evt_o` AND `inten_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsup_i | input | VW | Sampled supply code, 10 mV per unit |
| hfclk_on_i | input | 1 | High-frequency clock running |
| sys_on_i | input | 1 | System is on |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | Bit 0 enable, bits 4:1 threshold code |
| evt_clr_i | input | 1 | Software writes 0 to the event flag |
| inten_set_i | input | 1 | Write-1-to-set of the interrupt enable |
| inten_clr_i | input | 1 | Write-1-to-clear of the interrupt enable |
| evt_o | output | 1 | Sticky warning event flag |
| inten_o | output | 1 | Interrupt enable state |
| irq_o | output | 1 | Interrupt request |
| wr_inhibit_o | output | 1 | Flash write inhibit |

## Verification
The assertions assume that `vsup_i` and the other inputs change only between clock edges. They also assume that the supply code plus the hysteresis never exceeds the width of `vsup_i`. The bench drives every input on the falling edge and keeps the supply between 150 and 300 units. It sweeps the supply by single units, down and then up, once for each of the 16 threshold codes. This shows the exact level where the low-supply state is entered and where it is released. Directed sequences cover enabling, re-thresholding, clock and system sleep, and clear/set collisions, all with supplies well inside the code range.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  localparam int THR_W = 4;
  localparam int CFG_W = THR_W + 1;

  // bit 0 enable, bits 4:1 threshold code
  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic             en;
  } cfg_t;
endpackage

// File: rtl/pfw_cfg_reg.sv
module pfw_cfg_reg
  import pfw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             inten_set_i,
  input  logic             inten_clr_i,
  output cfg_t             cfg_o,
  output logic             inten_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= '0;
      inten_o <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_o <= cfg_t'(cfg_wdata_i);
      if (inten_clr_i)      inten_o <= 1'b0;
      else if (inten_set_i) inten_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pfw_cmp.sv
module pfw_cmp
  import pfw_pkg::*;
#(
  parameter int VW       = 9,
  parameter int HYST     = 5,
  parameter int THR_BASE = 170,
  parameter int THR_STEP = 10,
  parameter int THR_LO   = 4,
  parameter int THR_HI   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [VW-1:0]    vsup_i,
  output logic [VW-1:0]    thr_lvl_o,
  output logic             below_o,
  output logic             enter_o
);
  logic [THR_W-1:0] thr_sel;
  logic [VW:0]      rel_lvl;
  logic             below_d;

  always_comb begin
    if (thr_i < THR_W'(THR_LO))      thr_sel = THR_W'(THR_LO);
    else if (thr_i > THR_W'(THR_HI)) thr_sel = THR_W'(THR_HI);
    else                             thr_sel = thr_i;
    thr_lvl_o = VW'(THR_BASE + THR_STEP * (int'(thr_sel) - THR_LO));
  end

  assign rel_lvl = {1'b0, thr_lvl_o} + (VW+1)'(HYST);

  // sleeping comparator forgets its state, so wake-up counts as entry
  always_comb begin
    if (!active_i)    below_d = 1'b0;
    else if (below_o) below_d = ({1'b0, vsup_i} <= rel_lvl);
    else              below_d = (vsup_i < thr_lvl_o);
  end

  assign enter_o = below_d & ~below_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) below_o <= 1'b0;
    else         below_o <= below_d;
  end
endmodule

// File: rtl/pfw_evt.sv
module pfw_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic clr_i,
  input  logic inten_i,
  output logic evt_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      evt_o <= 1'b0;
    else if (enter_i) evt_o <= 1'b1;
    else if (clr_i)   evt_o <= 1'b0;
  end

  assign irq_o = evt_o & inten_i;
endmodule

// File: rtl/pfw_warn.sv
module pfw_warn
  import pfw_pkg::*;
#(
  parameter int VW       = 9,
  parameter int HYST     = 5,
  parameter int THR_BASE = 170,
  parameter int THR_STEP = 10,
  parameter int THR_LO   = 4,
  parameter int THR_HI   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VW-1:0]    vsup_i,
  input  logic             hfclk_on_i,
  input  logic             sys_on_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             evt_clr_i,
  input  logic             inten_set_i,
  input  logic             inten_clr_i,
  output logic             evt_o,
  output logic             inten_o,
  output logic             irq_o,
  output logic             wr_inhibit_o
);
  cfg_t          cfg_q;
  logic          cfg_en;
  logic          active;
  logic          below_q;
  logic          enter;
  logic [VW-1:0] thr_lvl;

  pfw_cfg_reg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .inten_set_i (inten_set_i),
    .inten_clr_i (inten_clr_i),
    .cfg_o       (cfg_q),
    .inten_o     (inten_o)
  );

  assign cfg_en = cfg_q.en;
  assign active = cfg_en & hfclk_on_i & sys_on_i;

  pfw_cmp #(
    .VW(VW), .HYST(HYST), .THR_BASE(THR_BASE),
    .THR_STEP(THR_STEP), .THR_LO(THR_LO), .THR_HI(THR_HI)
  ) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .thr_i     (cfg_q.thr),
    .vsup_i    (vsup_i),
    .thr_lvl_o (thr_lvl),
    .below_o   (below_q),
    .enter_o   (enter)
  );

  pfw_evt u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (enter),
    .clr_i   (evt_clr_i),
    .inten_i (inten_o),
    .evt_o   (evt_o),
    .irq_o   (irq_o)
  );

  assign wr_inhibit_o = below_q & active;
endmodule

// File: rtl/pfw_warn_chk.sv
module pfw_warn_chk #(
  parameter int VW   = 9,
  parameter int HYST = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hfclk_on_i,
  input logic          sys_on_i,
  input logic [VW-1:0] vsup_i,
  input logic [VW-1:0] thr_lvl,
  input logic          below_q,
  input logic          cfg_en,
  input logic          active,
  input logic          evt_o,
  input logic          evt_clr_i,
  input logic          inten_o,
  input logic          inten_clr_i,
  input logic          irq_o,
  input logic          wr_inhibit_o
);
  AST_NO_EVT_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hfclk_on_i && sys_on_i) |=> !$rose(evt_o)); // R8

  AST_INHIBIT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_inhibit_o |-> cfg_en && hfclk_on_i && sys_on_i && below_q); // R7

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o && !evt_clr_i |=> evt_o); // R9

  AST_EVT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_clr_i && below_q |=> !evt_o); // R9

  AST_EVT_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> $rose(below_q)); // R3

  AST_ENTRY_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !below_q && (vsup_i < thr_lvl) |=> below_q && evt_o); // R4

  AST_HYST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(below_q) && $past(active) |-> int'($past(vsup_i)) > int'($past(thr_lvl)) + HYST); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> evt_o && inten_o); // R10

  AST_INTEN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inten_clr_i |=> !inten_o); // R10
endmodule

bind pfw_warn pfw_warn_chk #(.VW(VW), .HYST(HYST)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hfclk_on_i   (hfclk_on_i),
  .sys_on_i     (sys_on_i),
  .vsup_i       (vsup_i),
  .thr_lvl      (thr_lvl),
  .below_q      (below_q),
  .cfg_en       (cfg_en),
  .active       (active),
  .evt_o        (evt_o),
  .evt_clr_i    (evt_clr_i),
  .inten_o      (inten_o),
  .inten_clr_i  (inten_clr_i),
  .irq_o        (irq_o),
  .wr_inhibit_o (wr_inhibit_o)
);

// File: tb/sim_pfw_warn.sv
`timescale 1ns/1ps
module sim_pfw_warn;
  localparam int VW = 9;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [VW-1:0] vsup_i = '0;
  logic          hfclk_on_i = 1'b1, sys_on_i = 1'b1;
  logic          cfg_we_i = 1'b0;
  logic [4:0]    cfg_wdata_i = '0;
  logic          evt_clr_i = 1'b0, inten_set_i = 1'b0, inten_clr_i = 1'b0;
  logic          evt_o, inten_o, irq_o, wr_inhibit_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  // bench model state
  logic m_en = 1'b0, m_below = 1'b0, m_evt = 1'b0, m_inten = 1'b0;
  int   m_thr = 0;

  always #4 clk_i = ~clk_i;

  pfw_warn #(.VW(VW)) u0 (.*);

  function automatic int lvl_of(input int code);
    int c;
    c = (code < 4) ? 4 : ((code > 10) ? 10 : code);
    return 170 + 10 * (c - 4);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic act, nb;
    int   v, lv;
    @(posedge clk_i); #1;
    act = m_en & hfclk_on_i & sys_on_i;
    v   = int'(vsup_i);
    lv  = lvl_of(m_thr);
    nb  = act & (m_below ? !(v > lv + 5) : (v < lv));
    if (nb && !m_below) m_evt = 1'b1;
    else if (evt_clr_i) m_evt = 1'b0;
    if (inten_clr_i)      m_inten = 1'b0;
    else if (inten_set_i) m_inten = 1'b1;
    if (cfg_we_i) begin
      m_en  = cfg_wdata_i[0];
      m_thr = int'(cfg_wdata_i[4:1]);
    end
    m_below = nb;
    cfg_we_i = 1'b0; evt_clr_i = 1'b0; inten_set_i = 1'b0; inten_clr_i = 1'b0;
    @(negedge clk_i);
    chk(cur_tag, "wr_inhibit_o", 32'(wr_inhibit_o), 32'(m_below & m_en & hfclk_on_i & sys_on_i));
    chk(cur_tag, "evt_o", 32'(evt_o), 32'(m_evt));
    chk(cur_tag, "irq_o", 32'(irq_o), 32'(m_evt & m_inten));
  endtask

  task automatic wr_cfg(input int code, input logic en);
    cfg_we_i = 1'b1;
    cfg_wdata_i = {4'(code), en};
    tick();
  endtask

  task automatic clr_evt();
    evt_clr_i = 1'b1;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int fall_at, rel_at, lv;
    vsup_i = VW'(300);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "evt_o", 32'(evt_o), 0);
    chk("R1", "inten_o", 32'(inten_o), 0);
    chk("R1", "irq_o", 32'(irq_o), 0);
    chk("R1", "wr_inhibit_o", 32'(wr_inhibit_o), 0);
    rst_ni = 1'b1;
    tick();

    // R2 R3 R6 sweep over every threshold code
    for (int t = 0; t < 16; t++) begin
      cur_tag = "R3";
      lv = lvl_of(t);
      vsup_i = VW'(300);
      wr_cfg(t, 1'b1);
      clr_evt();
      chk("R3", "evt_o before drop", 32'(evt_o), 0);
      fall_at = -1;
      for (int v = 300; v >= 150; v--) begin
        vsup_i = VW'(v);
        tick();
        if (fall_at < 0 && wr_inhibit_o) fall_at = v;
      end
      chk("R2", "entry supply code", 32'(fall_at), 32'(lv - 1));
      chk("R3", "evt_o after drop", 32'(evt_o), 1);
      cur_tag = "R6";
      clr_evt();
      rel_at = -1;
      for (int v = 150; v <= 300; v++) begin
        vsup_i = VW'(v);
        tick();
        if (rel_at < 0 && !wr_inhibit_o) rel_at = v;
      end
      chk("R6", "release supply code", 32'(rel_at), 32'(lv + 6));
      chk("R6", "no event while low", 32'(evt_o), 0);
    end

    // R4 enable while already low
    cur_tag = "R4";
    vsup_i = VW'(180);
    wr_cfg(6, 1'b0);
    clr_evt();
    chk("R7", "inhibit while disabled", 32'(wr_inhibit_o), 0);
    chk("R4", "evt_o while disabled", 32'(evt_o), 0);
    wr_cfg(6, 1'b1);
    tick();
    chk("R4", "evt_o on enable", 32'(evt_o), 1);
    chk("R7", "inhibit after enable", 32'(wr_inhibit_o), 1);

    // R5 raise threshold above supply
    cur_tag = "R5";
    vsup_i = VW'(200);
    wr_cfg(5, 1'b1);
    clr_evt();
    tick();
    chk("R5", "evt_o above level", 32'(evt_o), 0);
    chk("R5", "inhibit above level", 32'(wr_inhibit_o), 0);
    wr_cfg(8, 1'b1);
    tick();
    chk("R5", "evt_o after rethreshold", 32'(evt_o), 1);
    chk("R7", "inhibit after rethreshold", 32'(wr_inhibit_o), 1);

    // R8 sleep on clock off and system off
    cur_tag = "R8";
    clr_evt();
    hfclk_on_i = 1'b0;
    tick(); tick(); tick();
    chk("R8", "inhibit clock off", 32'(wr_inhibit_o), 0);
    chk("R8", "evt_o clock off", 32'(evt_o), 0);
    hfclk_on_i = 1'b1;
    tick();
    chk("R8", "evt_o on clock resume", 32'(evt_o), 1);
    clr_evt();
    sys_on_i = 1'b0;
    tick(); tick();
    chk("R8", "inhibit system off", 32'(wr_inhibit_o), 0);
    chk("R8", "evt_o system off", 32'(evt_o), 0);

    // R9 entry and clear in the same cycle
    cur_tag = "R9";
    sys_on_i = 1'b1;
    evt_clr_i = 1'b1;
    tick();
    chk("R9", "set wins over clear", 32'(evt_o), 1);
    tick(); tick();
    chk("R9", "event sticky", 32'(evt_o), 1);

    // R6 once per entry and hysteresis band
    cur_tag = "R6";
    clr_evt();
    repeat (5) tick();
    chk("R6", "single event per entry", 32'(evt_o), 0);
    vsup_i = VW'(215);
    repeat (3) tick();
    chk("R6", "held inside band", 32'(wr_inhibit_o), 1);
    vsup_i = VW'(216);
    tick();
    chk("R6", "released above band", 32'(wr_inhibit_o), 0);
    vsup_i = VW'(200);
    tick();
    chk("R6", "new entry fires", 32'(evt_o), 1);

    // R10 interrupt enable
    cur_tag = "R10";
    inten_set_i = 1'b1;
    tick();
    chk("R10", "inten_o set", 32'(inten_o), 1);
    chk("R10", "irq_o raised", 32'(irq_o), 1);
    inten_set_i = 1'b1; inten_clr_i = 1'b1;
    tick();
    chk("R10", "clear wins", 32'(inten_o), 0);
    chk("R10", "irq_o masked", 32'(irq_o), 0);
    inten_set_i = 1'b1;
    tick();
    chk("R10", "irq_o re-enabled", 32'(irq_o), 1);
    clr_evt();
    chk("R10", "irq_o after event clear", 32'(irq_o), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule